// File: doc/BRIEF.md
# One-Time-Programmable Array Write Controller

This block sits between a CPU bus and a one-time-programmable byte array. It holds a small control register with two coupled bits, a latch-arm bit and a pulse-enable bit. When software arms the latch, the next write that lands in the array window does not go to the array. Instead, the block captures that write's address and byte and presents them to the array on dedicated outputs. Software then raises the pulse-enable bit for the time the cells need. Finally it drops the latch bit, and that also removes the pulse.

While the latch is armed, array reads are suppressed. The array never sees a read strobe, the bus gets a zero byte, and a flag marks the read as blocked. When the latch is clear the array is read-only: reads pass through, and writes into the array window have no effect.

The interlock between the two bits is enforced in hardware. A single write cannot both arm the latch and start the pulse. The pulse cannot start until a target byte has been captured. Clearing the latch always takes the pulse and the captured pair down at the same clock edge.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After reset the latch bit, the pulse bit and the captured-pair flag are all clear, `prog_pulse` is 0, and a read of the control register returns 8'h00.
- R2: The control register sits at `CTRL_ADDR`, with the latch bit at bit 2 and the pulse bit at bit 0. A read returns those two bits in place and zeros in every other position.
- R3: A control write with bit 2 equal to 0 clears the latch bit, the pulse bit and the captured-pair flag, all at the same clock edge.
- R4: A control write with bit 2 equal to 1 while the latch is clear sets only the latch bit. The pulse bit stays 0 even when bit 0 of the written byte is 1.
- R5: A control write with bit 2 equal to 1 while the latch is set loads the pulse bit from bit 0 of the written byte, but only if a pair has been captured. Without a captured pair the pulse bit stays 0.
- R6: While the latch is set and no pair is held, the first write into the array window loads its address onto `prog_addr` and its byte onto `prog_data`. Later array writes leave both outputs unchanged until the latch has been cleared and set again.
- R7: While the latch is set, an array-window read returns 8'h00, raises `rd_blocked` and keeps `arr_rd_en` low.
- R8: While the latch is clear, an array-window read raises `arr_rd_en`, returns `arr_rdata` on `bus_rdata`, and keeps `rd_blocked` low.
- R9: While the latch is clear, writes into the array window change neither `prog_addr` nor `prog_data`, and they do not count as a captured pair.
- R10: `prog_pulse` is high exactly while the pulse bit is set.
- R11: A read of an address that is neither the control register nor in the array window returns 8'h00, and `bus_rdata` is 8'h00 whenever `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | CPU byte address |
| bus_wdata | input | 8 | CPU write byte |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read byte, combinational |
| rd_blocked | output | 1 | Array read suppressed because the latch is armed |
| arr_raddr | output | AW | Read address to the array |
| arr_rd_en | output | 1 | Read enable to the array |
| arr_rdata | input | 8 | Read byte from the array |
| prog_addr | output | AW | Captured programming address |
| prog_data | output | 8 | Captured programming byte |
| prog_pulse | output | 1 | Programming pulse enable to the array |

## Verification
Two things can land on the same clock edge: a control write that clears the latch, and the fall of a running pulse together with the loss of the captured pair. A control write that arms the latch and also asks for the pulse is a similar collision. The bench reaches each of the four states (idle, armed, armed with a pair, pulsing) and writes every possible byte to the control register from each one. After every write it checks the register readback and `prog_pulse` against an arithmetic model of the bit rules. Each state is then re-entered to confirm that the pair was dropped or kept as expected.

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl #(
  parameter int AW        = 13,
  parameter int CTRL_ADDR = 'h01C,
  parameter int ARR_BASE  = 'h100,
  parameter int ARR_WORDS = 256,
  parameter int LAT_BIT   = 2,
  parameter int PGM_BIT   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [7:0]    bus_rdata,
  output logic          rd_blocked,
  output logic [AW-1:0] arr_raddr,
  output logic          arr_rd_en,
  input  logic [7:0]    arr_rdata,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data,
  output logic          prog_pulse
);
  localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);
  localparam logic [AW-1:0] ARR_LO = AW'(ARR_BASE);
  localparam logic [AW-1:0] ARR_HI = AW'(ARR_BASE + ARR_WORDS - 1);

  logic lat_q, pgm_q, pair_q;
  logic [7:0] ctrl_val;

  wire ctrl_hit = (bus_addr == CTRL_A);
  wire in_arr   = (bus_addr >= ARR_LO) && (bus_addr <= ARR_HI);
  wire ctrl_wr  = bus_we & ctrl_hit;
  wire arr_wr   = bus_we & in_arr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q     <= 1'b0;
      pgm_q     <= 1'b0;
      pair_q    <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
    end else if (ctrl_wr) begin
      if (!bus_wdata[LAT_BIT]) begin
        lat_q  <= 1'b0;
        pgm_q  <= 1'b0;
        pair_q <= 1'b0;
      end else if (!lat_q) begin
        lat_q <= 1'b1;
        pgm_q <= 1'b0;
      end else begin
        pgm_q <= bus_wdata[PGM_BIT] & pair_q;
      end
    end else if (arr_wr && lat_q && !pair_q) begin
      prog_addr <= bus_addr;
      prog_data <= bus_wdata;
      pair_q    <= 1'b1;
    end
  end

  always_comb begin
    ctrl_val          = 8'h00;
    ctrl_val[LAT_BIT] = lat_q;
    ctrl_val[PGM_BIT] = pgm_q;
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_re) begin
      if (ctrl_hit)            bus_rdata = ctrl_val;
      else if (in_arr && !lat_q) bus_rdata = arr_rdata;
    end
  end

  assign rd_blocked = bus_re & in_arr & lat_q;
  assign arr_rd_en  = bus_re & in_arr & ~lat_q;
  assign arr_raddr  = bus_addr;
  assign prog_pulse = pgm_q;
endmodule

// File: rtl/otp_prog_ctrl_chk.sv
module otp_prog_ctrl_chk #(
  parameter int AW        = 13,
  parameter int CTRL_ADDR = 'h01C
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic          wr_lat,
  input logic          bus_re,
  input logic [7:0]    bus_rdata,
  input logic          rd_blocked,
  input logic          arr_rd_en,
  input logic [AW-1:0] prog_addr,
  input logic [7:0]    prog_data,
  input logic          prog_pulse,
  input logic          lat_q,
  input logic          pair_q
);
  wire ctrl_wr = bus_we && (bus_addr == AW'(CTRL_ADDR));

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> !prog_pulse && !lat_q && !pair_q);

  p_clear_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wr_lat) |=> (!lat_q && !prog_pulse && !pair_q));

  p_latch_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_lat && !lat_q) |=> (lat_q && !prog_pulse));

  p_pulse_needs_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |-> (lat_q && pair_q));

  p_hold_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_q && !ctrl_wr) |=> (pair_q && $stable(prog_addr) && $stable(prog_data)));

  p_block_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_blocked |-> (bus_rdata == 8'h00 && !arr_rd_en && lat_q));

  p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> (bus_rdata == 8'h00 && !rd_blocked && !arr_rd_en));
endmodule

bind otp_prog_ctrl otp_prog_ctrl_chk #(.AW(AW), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .wr_lat(bus_wdata[LAT_BIT]), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .rd_blocked(rd_blocked), .arr_rd_en(arr_rd_en), .prog_addr(prog_addr),
  .prog_data(prog_data), .prog_pulse(prog_pulse), .lat_q(lat_q), .pair_q(pair_q)
);

// File: tb/otp_prog_ctrl_tb.sv
module otp_prog_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int AW = 13;
  localparam int CTRL = 'h01C;
  localparam int BASE = 'h100;
  localparam int WORDS = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_rdata, arr_rdata;
  logic rd_blocked, arr_rd_en, prog_pulse;
  logic [AW-1:0] arr_raddr, prog_addr;
  logic [7:0] prog_data;
  int n_chk = 0, n_bad = 0;
  bit m_lat, m_pgm, m_pair;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] arr_val(input logic [AW-1:0] a);
    return a[7:0] * 8'd7 + 8'h3C;
  endfunction
  assign arr_rdata = arr_rd_en ? arr_val(arr_raddr) : 8'hEE;

  otp_prog_ctrl #(.AW(AW), .CTRL_ADDR(CTRL), .ARR_BASE(BASE), .ARR_WORDS(WORDS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .rd_blocked(rd_blocked),
    .arr_raddr(arr_raddr), .arr_rd_en(arr_rd_en), .arr_rdata(arr_rdata),
    .prog_addr(prog_addr), .prog_data(prog_data), .prog_pulse(prog_pulse));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d, output logic blk, output logic en);
    @(negedge clk);
    bus_addr = AW'(a); bus_re = 1'b1;
    #(CLK_P/4);
    d = bus_rdata; blk = rd_blocked; en = arr_rd_en;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  function automatic logic [7:0] m_ctrl();
    return {5'b0, m_lat, 1'b0, m_pgm};
  endfunction

  task automatic m_wr(input logic [7:0] d);
    if (!d[2]) begin m_lat = 0; m_pgm = 0; m_pair = 0; end
    else if (!m_lat) begin m_lat = 1; m_pgm = 0; end
    else m_pgm = d[0] & m_pair;
  endtask

  task automatic enter(input int s);
    wr(CTRL, 8'h00); m_lat = 0; m_pgm = 0; m_pair = 0;
    if (s >= 1) begin wr(CTRL, 8'h04); m_lat = 1; end
    if (s >= 2) begin wr(BASE + 5, 8'h5A); m_pair = 1; end
    if (s >= 3) begin wr(CTRL, 8'h05); m_pgm = 1; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d; logic blk, en;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 pulse", {31'b0, prog_pulse}, 0);
    rd(CTRL, d, blk, en);
    chk("R1 ctrl", {24'b0, d}, 0);
    chk("R11 idle rdata", {24'b0, bus_rdata}, 0);

    // R2 R3 R4 R5 R10: every control byte from every state
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 256; v++) begin
        enter(s);
        wr(CTRL, 8'(v)); m_wr(8'(v));
        chk(s == 0 ? "R4 pulse" : (v[2] ? "R5 pulse" : "R3 pulse"), {31'b0, prog_pulse}, {31'b0, m_pgm});
        rd(CTRL, d, blk, en);
        chk(v[2] ? "R2 ctrl readback" : "R3 ctrl readback", {24'b0, d}, {24'b0, m_ctrl()});
        // R10 pulse follows bit; R3 pair kept or dropped shows on a retry
        if (m_lat) begin
          wr(CTRL, 8'h05); m_wr(8'h05);
          chk("R10 pulse after retry", {31'b0, prog_pulse}, {31'b0, m_pgm});
        end
      end
    end

    // R6 first array write captured, later ignored
    enter(1);
    wr(BASE + 8'h33, 8'hC7);
    chk("R6 addr", {19'b0, prog_addr}, BASE + 8'h33);
    chk("R6 data", {24'b0, prog_data}, 8'hC7);
    wr(BASE + 8'h40, 8'h11);
    chk("R6 addr held", {19'b0, prog_addr}, BASE + 8'h33);
    chk("R6 data held", {24'b0, prog_data}, 8'hC7);
    wr(CTRL, 8'h05);
    chk("R10 pulse on", {31'b0, prog_pulse}, 1);
    wr(CTRL, 8'h00);
    chk("R3 pulse off with latch", {31'b0, prog_pulse}, 0);

    // R9 writes ignored while latch clear
    wr(BASE + 8'h77, 8'h99);
    chk("R9 addr unchanged", {19'b0, prog_addr}, BASE + 8'h33);
    chk("R9 data unchanged", {24'b0, prog_data}, 8'hC7);
    wr(CTRL, 8'h04); wr(CTRL, 8'h05);
    chk("R9 no pair from unlatched write", {31'b0, prog_pulse}, 0);
    wr(BASE + 8'h08, 8'h3E);
    chk("R6 fresh capture addr", {19'b0, prog_addr}, BASE + 8'h08);
    chk("R6 fresh capture data", {24'b0, prog_data}, 8'h3E);

    // R7 blocked reads over whole window
    for (int a = 0; a < WORDS; a++) begin
      rd(BASE + a, d, blk, en);
      chk("R7 rdata", {24'b0, d}, 0);
      chk("R7 blocked", {30'b0, blk, en}, 2'b10);
    end
    // R8 normal reads over whole window
    wr(CTRL, 8'h00);
    for (int a = 0; a < WORDS; a++) begin
      rd(BASE + a, d, blk, en);
      chk("R8 rdata", {24'b0, d}, {24'b0, arr_val(AW'(BASE + a))});
      chk("R8 flags", {30'b0, blk, en}, 2'b01);
    end
    // R11 unmapped reads
    rd(BASE - 1, d, blk, en);  chk("R11 below window", {24'b0, d}, 0);
    rd(BASE + WORDS, d, blk, en); chk("R11 above window", {24'b0, d}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule